// File: doc/BRIEF.md
# Warp memory access coalescer

This block turns one memory instruction from a 32-lane warp into the fewest naturally aligned memory transactions that cover every active lane. The input is a per-lane active mask, one byte address per lane and an element size of 1, 2, 4 or 8 bytes. Active lanes are grouped by the 128-byte line they fall in. Each distinct line produces one transaction, and the lines are issued in ascending address order. When every lane in a line sits inside a single aligned 32-byte or 64-byte sub-range, the transaction is shrunk to that size. Each transaction carries its base address, a size code and the exact set of lanes it serves.

Transactions leave one per cycle on a valid/ready request port. A one-cycle done pulse follows the last transaction of a warp. A new warp is accepted only when the block is idle again, which is after that pulse. Each lane address is rounded down to a multiple of its element size, so an element never crosses a 32-byte sub-range. Cache lookup, data return and write merging sit outside this block.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, req_ready is 1, txn_valid is 0 and done is 0.
- R2: When all active lanes fall in one 128-byte line and occupy both of its 64-byte halves, exactly one transaction is issued. Its txn_size is code 2 (128 bytes), its txn_addr is the line base, and its txn_lanes equals the active mask. Example: 32 lanes reading consecutive 4-byte words from a 128-byte boundary.
- R3: One transaction is issued per distinct 128-byte line touched. For example, 32 consecutive 8-byte elements from a 128-byte boundary give two 128-byte transactions: lanes 0-15 in the first and lanes 16-31 in the second. Fully scattered lanes give one transaction each.
- R4: txn_size codes are 0 = 32 bytes, 1 = 64 bytes and 2 = 128 bytes. If all lanes of a line lie in one aligned 32-byte sub-range, code 0 is used. Otherwise, if they lie in one aligned 64-byte half, code 1 is used. req_size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. A warp of consecutive 1-byte elements therefore gives one 32-byte transaction, and a warp of 2-byte elements gives one 64-byte transaction.
- R5: Every txn_addr is a multiple of the size its txn_size encodes.
- R6: Transactions of one warp are issued in strictly ascending txn_addr order. Each txn_lanes is non-empty and disjoint from the others, and their union equals the active mask.
- R7: A lane whose mask bit is 0 contributes no address to any transaction. A warp with an all-zero mask issues no transaction, and done rises in the cycle after acceptance.
- R8: While txn_valid is 1 and txn_ready is 0, txn_valid stays 1 and txn_addr, txn_size and txn_lanes hold their values.
- R9: done is a single-cycle pulse in the cycle after the last transaction handshake. txn_valid is 0 while done is 1.
- R10: req_ready is 0 from the cycle after a warp is accepted through the done pulse, and it is 1 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp instruction offered |
| req_ready | output | 1 | Block idle and able to take a warp |
| req_mask | input | 32 | Active-lane mask, bit i for lane i |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32i+31:32i] |
| req_size | input | 2 | Element size code (1/2/4/8 bytes) |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Memory side accepts the transaction |
| txn_addr | output | 32 | Aligned transaction base address |
| txn_size | output | 2 | Transaction size code (32/64/128 bytes) |
| txn_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the warp's last transaction |

## Verification
Some properties are checked on every cycle. Transactions must hold steady under back-pressure and must be aligned to their own size. Bases must rise within a warp. Lane sets must be non-empty, disjoint and drawn from the accepted mask, and they must add up to that mask by the time done pulses. Request acceptance must stay closed while a warp is in flight. These checks do not show whether the grouping is minimal or whether a segment was shrunk to the right size. The directed scenarios cover that by comparing every transaction against a model built from the requirements: consecutive elements of each width, scattered lanes, partial masks, an empty warp and stalled acceptance.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int LINE_SHIFT = 7;   // 128-byte line
    localparam int SUB_SHIFT  = 5;   // 32-byte sub-range
    localparam int SUBS_LOG2  = LINE_SHIFT - SUB_SHIFT;

    typedef enum logic [1:0] {
        ELEM_B1 = 2'd0,
        ELEM_B2 = 2'd1,
        ELEM_B4 = 2'd2,
        ELEM_B8 = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        SEG_32  = 2'd0,
        SEG_64  = 2'd1,
        SEG_128 = 2'd2
    } seg_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } coal_state_e;

    typedef struct packed {
        seg_size_e             size;
        logic [SUBS_LOG2-1:0]  sub_idx;
    } seg_shape_t;

    // low address bits cleared to align an element to its own size
    function automatic logic [2:0] elem_low_bits(elem_size_e s);
        case (s)
            ELEM_B1: return 3'b000;
            ELEM_B2: return 3'b001;
            ELEM_B4: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [LANES-1:0]       load_mask,
    input  logic [LANES*AW-1:0]    load_addr,
    input  coal_pkg::elem_size_e   load_size,
    input  logic                   retire,
    input  logic [LANES-1:0]       retire_mask,
    output logic [LANES-1:0]       pending,
    output logic [LANES*AW-1:0]    lane_addr
);
    logic [AW-1:0] align_mask;
    assign align_mask = ~AW'(coal_pkg::elem_low_bits(load_size));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                lane_addr[i*AW +: AW] <= '0;
            else if (load)
                lane_addr[i*AW +: AW] <= load_addr[i*AW +: AW] & align_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending <= '0;
        else if (load)
            pending <= load_mask;
        else if (retire)
            pending <= pending & ~retire_mask;
    end
endmodule

// File: rtl/coal_line_min.sv
module coal_line_min #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    localparam int LW   = AW - coal_pkg::LINE_SHIFT
) (
    input  logic [LANES-1:0]     pending,
    input  logic [LANES*AW-1:0]  lane_addr,
    output logic                 any,
    output logic [LW-1:0]        min_line
);
    logic [LW-1:0]    line_of [LANES];
    logic [LANES-1:0] low_unused;

    for (genvar i = 0; i < LANES; i++) begin : g_line
        assign line_of[i]    = lane_addr[i*AW + coal_pkg::LINE_SHIFT +: LW];
        assign low_unused[i] = ^lane_addr[i*AW +: coal_pkg::LINE_SHIFT];
    end

    always_comb begin
        any      = 1'b0;
        min_line = '1;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i] && (!any || line_of[i] < min_line)) begin
                min_line = line_of[i];
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/coal_seg_shaper.sv
module coal_seg_shaper #(
    parameter int LANES = 32,
    parameter int AW    = 32,
    localparam int LW   = AW - coal_pkg::LINE_SHIFT,
    localparam int SW   = coal_pkg::SUBS_LOG2
) (
    input  logic [LANES-1:0]      pending,
    input  logic [LANES*AW-1:0]   lane_addr,
    input  logic [LW-1:0]         min_line,
    output logic [LANES-1:0]      seg_mask,
    output logic [AW-1:0]         seg_addr,
    output coal_pkg::seg_shape_t  shape
);
    import coal_pkg::*;

    logic [SW-1:0]    sub_of [LANES];
    logic [LANES-1:0] same_sub;
    logic [LANES-1:0] same_half;
    logic [LANES-1:0] low_unused;
    logic [SW-1:0]    ref_sub;
    logic             found;

    for (genvar i = 0; i < LANES; i++) begin : g_hit
        assign seg_mask[i]   = pending[i] &&
                               (lane_addr[i*AW + LINE_SHIFT +: LW] == min_line);
        assign sub_of[i]     = lane_addr[i*AW + SUB_SHIFT +: SW];
        assign low_unused[i] = ^lane_addr[i*AW +: SUB_SHIFT];
    end

    // sub-range of the lowest-numbered lane in the segment
    always_comb begin
        ref_sub = '0;
        found   = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (seg_mask[i] && !found) begin
                ref_sub = sub_of[i];
                found   = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_agree
        assign same_sub[i]  = !seg_mask[i] || (sub_of[i] == ref_sub);
        assign same_half[i] = !seg_mask[i] || (sub_of[i][SW-1] == ref_sub[SW-1]);
    end

    always_comb begin
        shape.sub_idx = ref_sub;
        if (&same_sub) begin
            shape.size = SEG_32;
            seg_addr   = {min_line, ref_sub, {SUB_SHIFT{1'b0}}};
        end else if (&same_half) begin
            shape.size = SEG_64;
            seg_addr   = {min_line, ref_sub[SW-1], {(SUB_SHIFT+1){1'b0}}};
        end else begin
            shape.size = SEG_128;
            seg_addr   = {min_line, {LINE_SHIFT{1'b0}}};
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [LANES-1:0]     req_mask,
    input  logic [LANES*AW-1:0]  req_addr,
    input  logic [1:0]           req_size,
    output logic                 txn_valid,
    input  logic                 txn_ready,
    output logic [AW-1:0]        txn_addr,
    output logic [1:0]           txn_size,
    output logic [LANES-1:0]     txn_lanes,
    output logic                 done
);
    import coal_pkg::*;

    localparam int LW = AW - LINE_SHIFT;

    coal_state_e          state, state_nx;
    logic                 accept, fire, last;
    logic [LANES-1:0]     pending;
    logic [LANES*AW-1:0]  lane_addr;
    logic                 any_pending;
    logic [LW-1:0]        min_line;
    logic [LANES-1:0]     seg_mask;
    logic [AW-1:0]        seg_addr;
    seg_shape_t           shape;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign txn_valid = (state == ST_ISSUE) && any_pending;
    assign fire      = txn_valid && txn_ready;
    assign last      = (pending & ~seg_mask) == '0;
    assign done      = (state == ST_DONE);
    assign txn_addr  = seg_addr;
    assign txn_size  = shape.size;
    assign txn_lanes = seg_mask;

    coal_lane_store #(.LANES(LANES), .AW(AW)) u_store (
        .clk         (clk),
        .rst         (rst),
        .load        (accept),
        .load_mask   (req_mask),
        .load_addr   (req_addr),
        .load_size   (elem_size_e'(req_size)),
        .retire      (fire),
        .retire_mask (seg_mask),
        .pending     (pending),
        .lane_addr   (lane_addr)
    );

    coal_line_min #(.LANES(LANES), .AW(AW)) u_min (
        .pending  (pending),
        .lane_addr(lane_addr),
        .any      (any_pending),
        .min_line (min_line)
    );

    coal_seg_shaper #(.LANES(LANES), .AW(AW)) u_shape (
        .pending  (pending),
        .lane_addr(lane_addr),
        .min_line (min_line),
        .seg_mask (seg_mask),
        .seg_addr (seg_addr),
        .shape    (shape)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (accept) state_nx = (req_mask == '0) ? ST_DONE : ST_ISSUE;
            ST_ISSUE: if (!any_pending || (fire && last)) state_nx = ST_DONE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end
endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
    parameter int LANES = 32,
    parameter int AW    = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [LANES-1:0]  req_mask,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [AW-1:0]     txn_addr,
    input logic [1:0]        txn_size,
    input logic [LANES-1:0]  txn_lanes,
    input logic              done
);
    logic             busy, have_prev;
    logic [LANES-1:0] accepted, served;
    logic [AW-1:0]    prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; have_prev <= 1'b0;
            accepted <= '0; served <= '0; prev_addr <= '0;
        end else if (req_valid && req_ready) begin
            busy <= 1'b1; have_prev <= 1'b0;
            accepted <= req_mask; served <= '0;
        end else begin
            if (txn_valid && txn_ready) begin
                served    <= served | txn_lanes;
                have_prev <= 1'b1;
                prev_addr <= txn_addr;
            end
            if (done) busy <= 1'b0;
        end
    end

    // R8
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr)
            && $stable(txn_size) && $stable(txn_lanes));

    // R5
    aligned_base_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_size == 2'd0 && txn_addr[4:0] == 5'd0)
                   || (txn_size == 2'd1 && txn_addr[5:0] == 6'd0)
                   || (txn_size == 2'd2 && txn_addr[6:0] == 7'd0));

    // R6
    lanes_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_lanes != '0 && (txn_lanes & ~accepted) == '0
                   && (txn_lanes & served) == '0);

    // R6
    ascending_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid && have_prev |-> txn_addr > prev_addr);

    // R6
    full_cover_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> served == accepted);

    // R9
    done_alone_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !txn_valid);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    closed_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready);
endmodule

bind warp_coalescer coal_checker #(.LANES(LANES), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_mask(req_mask), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_size(txn_size), .txn_lanes(txn_lanes),
    .done(done)
);

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [LANES-1:0] req_mask = '0;
    logic [LANES*AW-1:0] req_addr = '0;
    logic [1:0] req_size = 2'd0;
    logic txn_valid, txn_ready = 1'b0, done;
    logic [AW-1:0] txn_addr;
    logic [1:0] txn_size;
    logic [LANES-1:0] txn_lanes;

    int checks = 0, fails = 0;

    logic [31:0] lane_a [LANES];
    logic [31:0] e_addr [LANES];
    logic [1:0]  e_size [LANES];
    logic [31:0] e_lanes [LANES];
    int          e_n;
    logic [31:0] g_addr [LANES];
    logic [1:0]  g_size [LANES];
    logic [31:0] g_lanes [LANES];
    int          g_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_coalescer #(.LANES(LANES), .AW(AW)) u_warp_coalescer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .req_size(req_size),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_addr(txn_addr),
        .txn_size(txn_size), .txn_lanes(txn_lanes), .done(done)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    // expected transactions from the requirement text
    task automatic build_expect(input logic [31:0] mask);
        logic [31:0] left;
        left = mask;
        e_n = 0;
        while (left != 0) begin
            logic [24:0] lo;
            logic [31:0] seg;
            logic [1:0] rs;
            bit first, s32, s64;
            first = 1'b1; lo = '0;
            for (int i = 0; i < LANES; i++)
                if (left[i] && (first || lane_a[i][31:7] < lo)) begin
                    lo = lane_a[i][31:7]; first = 1'b0;
                end
            seg = '0; first = 1'b1; rs = '0; s32 = 1'b1; s64 = 1'b1;
            for (int i = 0; i < LANES; i++)
                if (left[i] && lane_a[i][31:7] == lo) begin
                    seg[i] = 1'b1;
                    if (first) begin rs = lane_a[i][6:5]; first = 1'b0; end
                    if (lane_a[i][6:5] != rs) s32 = 1'b0;
                    if (lane_a[i][6] != rs[1]) s64 = 1'b0;
                end
            e_lanes[e_n] = seg;
            if (s32) begin e_size[e_n] = 2'd0; e_addr[e_n] = {lo, rs, 5'd0}; end
            else if (s64) begin e_size[e_n] = 2'd1; e_addr[e_n] = {lo, rs[1], 6'd0}; end
            else begin e_size[e_n] = 2'd2; e_addr[e_n] = {lo, 7'd0}; end
            e_n++;
            left = left & ~seg;
        end
    endtask

    // drive one warp, collect its transactions; stall = idle cycles of txn_ready
    task automatic run_warp(input string tag, input logic [31:0] mask,
                            input logic [1:0] sz, input int stall);
        int cyc;
        bit fired_prev, held_prev, saw_done;
        logic [31:0] h_addr; logic [1:0] h_size; logic [31:0] h_lanes;
        build_expect(mask);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R10 idle ready"}, req_ready, 1);
        req_valid = 1'b1; req_mask = mask; req_size = sz;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = lane_a[i];
        @(negedge clk);
        req_valid = 1'b0;
        g_n = 0; cyc = 0; fired_prev = 1'b1; held_prev = 1'b0; saw_done = 1'b0;
        h_addr = '0; h_size = '0; h_lanes = '0;
        while (!saw_done && cyc < 2000) begin
            txn_ready = ((cyc % (stall + 1)) == stall);
            #1;
            if (done) begin
                saw_done = 1'b1;
                chk(fired_prev, {tag, " R9 done right after last handshake"}, 0, 1);
                chk(!txn_valid, {tag, " R9 no txn with done"}, txn_valid, 0);
            end else begin
                chk(!req_ready, {tag, " R10 closed while busy"}, req_ready, 0);
                if (held_prev)
                    chk(txn_valid && txn_addr == h_addr && txn_size == h_size
                        && txn_lanes == h_lanes, {tag, " R8 held under stall"},
                        txn_addr, h_addr);
                held_prev = txn_valid && !txn_ready;
                h_addr = txn_addr; h_size = txn_size; h_lanes = txn_lanes;
                fired_prev = txn_valid && txn_ready;
                if (fired_prev && g_n < LANES) begin
                    g_addr[g_n] = txn_addr; g_size[g_n] = txn_size;
                    g_lanes[g_n] = txn_lanes; g_n++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        chk(saw_done, {tag, " R9 done seen"}, saw_done, 1);
        chk(g_n == e_n, {tag, " transaction count"}, g_n, e_n);
        for (int k = 0; k < e_n && k < g_n; k++) begin
            chk(g_addr[k] == e_addr[k], {tag, " addr"}, g_addr[k], e_addr[k]);
            chk(g_size[k] == e_size[k], {tag, " size"}, g_size[k], e_size[k]);
            chk(g_lanes[k] == e_lanes[k], {tag, " lanes"}, g_lanes[k], e_lanes[k]);
        end
        @(negedge clk);
        txn_ready = 1'b0;
        #1;
        chk(req_ready == 1'b1 && done == 1'b0, {tag, " R10 R9 reopen after done"}, req_ready, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
        chk(txn_valid == 1'b0, "R1 reset txn_valid", txn_valid, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
    endtask

    task automatic t_words4;   // R2
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h1000 + 4*i;
        run_warp("R2 4B consecutive", 32'hFFFF_FFFF, 2'd2, 0);
        chk(e_n == 1 && e_size[0] == 2'd2, "R2 model one 128B", e_n, 1);
    endtask

    task automatic t_words8;   // R3
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h2000 + 8*i;
        run_warp("R3 8B consecutive", 32'hFFFF_FFFF, 2'd3, 1);
        chk(g_n == 2 && g_lanes[0] == 32'h0000_FFFF && g_addr[1] == 32'h2080,
            "R3 two 128B halves", g_lanes[0], 32'h0000_FFFF);
    endtask

    task automatic t_bytes;    // R4
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h3000 + i;
        run_warp("R4 1B consecutive", 32'hFFFF_FFFF, 2'd0, 0);
        chk(g_n == 1 && g_size[0] == 2'd0, "R4 one 32B", g_size[0], 0);
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h3040 + 2*i;
        run_warp("R4 2B consecutive", 32'hFFFF_FFFF, 2'd1, 2);
        chk(g_n == 1 && g_size[0] == 2'd1 && g_addr[0] == 32'h3040,
            "R4 one 64B upper half", g_addr[0], 32'h3040);
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h5020 + 2*i;
        run_warp("R4 64B straddle grows to 128B", 32'hFFFF_FFFF, 2'd1, 0);
        chk(g_n == 1 && g_size[0] == 2'd2 && g_addr[0] == 32'h5000,
            "R4 R5 straddling halves", g_addr[0], 32'h5000);
    endtask

    task automatic t_scatter;  // R6
        for (int i = 0; i < LANES; i++) lane_a[i] = (31 - i) * 256 + 4;
        run_warp("R6 scattered descending", 32'hFFFF_FFFF, 2'd2, 0);
        chk(g_n == 32 && g_lanes[0] == 32'h8000_0000 && g_addr[0] == 32'h0,
            "R6 ascending first is lane 31", g_lanes[0], 32'h8000_0000);
    endtask

    task automatic t_partial;  // R7
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h4000 + 4*i;
        for (int i = 8; i < LANES; i++) lane_a[i] = 32'hF000_0000 + 128*i;
        run_warp("R7 lanes 0-7 only", 32'h0000_00FF, 2'd2, 0);
        chk(g_n == 1 && g_lanes[0] == 32'h0000_00FF && g_size[0] == 2'd0,
            "R7 inactive lanes ignored", g_lanes[0], 32'hFF);
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h6000 + 4*i;
        for (int i = 8; i < 16; i++) lane_a[i] = 32'h6100 + 4*i;
        run_warp("R7 R6 two groups", 32'h0000_FFFF, 2'd2, 3);
        run_warp("R7 empty warp", 32'h0, 2'd2, 0);
        chk(g_n == 0, "R7 empty warp no txn", g_n, 0);
    endtask

    task automatic t_broadcast;
        for (int i = 0; i < LANES; i++) lane_a[i] = 32'h7FFC;
        run_warp("R4 broadcast", 32'hFFFF_FFFF, 2'd2, 0);
        chk(g_n == 1 && g_addr[0] == 32'h7FE0 && g_size[0] == 2'd0,
            "R4 R5 broadcast 32B", g_addr[0], 32'h7FE0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_words4();
        t_words8();
        t_bytes();
        t_scatter();
        t_partial();
        t_broadcast();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule